// File: doc/BRIEF.md
# Machine Cycle State Sequencer

This block paces a small 8-bit processor core. It turns two active-low control pins into an operating mode. It counts input clocks into fixed-length machine cycles and decides which machine state each new cycle runs in: fetch, execute, DMA or interrupt. It also drives two timing pulses inside every cycle. It gives the register file a clear strobe while reset is held, and an init strobe during the longer initialization cycle that follows reset. A flag tells the rest of the core that the part is in load mode, the idle mode in which an external device fills memory through DMA-in.

All sequencing state advances on the falling edge of the input clock. This is the edge on which pause freezes the timing and run restarts it. Decode supplies a flag that says whether the current instruction needs a second execute cycle. DMA and interrupt requests are plain level inputs, and the interrupt request only counts when the interrupt-enable input is high. Every port is a plain control or status pin. No data stream crosses this block, so there is no handshake.

Top module: `cycle_sequencer`

## Requirements
- R1: The pins {clear_n, wait_n} select the mode on each falling edge: 00 load, 01 reset, 10 pause, 11 run. `load_mode` is high only in load. `reg_clear` is high only in reset.
- R2: While reset is held, `state` reads 01 (execute), `phase` reads 0, and both `tpa` and `tpb` are low.
- R3: The first machine cycle after reset is released lasts 9 clocks, with `phase` stepping 0 to 8. Throughout it `state` stays 01 and `init_cycle` is high, even when DMA or interrupt requests are present.
- R4: The cycle that follows initialization is DMA (10) if either DMA request is high at its last edge, and otherwise fetch (00). It is never interrupt (11).
- R5: Every other machine cycle lasts 8 clocks, with `phase` stepping 0 to 7. The state code changes only on the edge that returns `phase` to 0.
- R6: Fetch (00) is always followed by execute (01). In run mode, an execute cycle that ends with `long_exec` high and is the first execute cycle of the instruction is followed by a second execute cycle.
- R7: In run mode, the last execute cycle, a DMA cycle and an interrupt cycle each hand over to one of three states. DMA (10) comes first, when dma_in_req or dma_out_req is high. Interrupt (11) comes next, when int_req and int_en are both high. Fetch (00) is used otherwise. A held DMA request therefore repeats DMA cycles.
- R8: Requests are ignored at the end of a fetch cycle and at the end of a first execute cycle that leads into a second one. An interrupt request with int_en low is ignored.
- R9: In pause mode, `phase` and `state` hold their values on every falling edge. When run returns, counting resumes from the held phase on the next falling edge.
- R10: Outside reset, `tpa` is high exactly while `phase` is 1 and `tpb` exactly while `phase` is 6. Each is therefore a one-clock pulse per running cycle.
- R11: In load mode, every cycle end goes to DMA (10) when a DMA request is high and to idle execute (01) otherwise. Load mode never enters fetch or interrupt, and ignores `long_exec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; sequencing acts on its falling edge |
| clear_n | input | 1 | Active-low mode pin, upper bit of the mode code |
| wait_n | input | 1 | Active-low mode pin, lower bit of the mode code |
| dma_in_req | input | 1 | DMA-in request |
| dma_out_req | input | 1 | DMA-out request |
| int_req | input | 1 | Interrupt request |
| int_en | input | 1 | Interrupt enable; qualifies int_req |
| long_exec | input | 1 | From decode: instruction needs a second execute cycle |
| state | output | 2 | Machine state: 00 fetch, 01 execute, 10 DMA, 11 interrupt |
| phase | output | PW (4) | Clock count within the current machine cycle |
| tpa | output | 1 | Early timing pulse, phase 1 |
| tpb | output | 1 | Late timing pulse, phase 6 |
| reg_clear | output | 1 | Reset strobe to the register file (clears instruction, opcode and output registers) |
| init_cycle | output | 1 | High during the initialization cycle (clears the pointer selectors and register 0) |
| load_mode | output | 1 | High in load mode |

## Verification
Pins are driven 1 ns after a rising edge and take effect on the falling edge that follows. `phase`, `state` and `init_cycle` are therefore due at the next rising edge, one clock after the stimulus. `tpa`, `tpb`, `reg_clear` and `load_mode` are due at the same point. A new state appears exactly 8 clocks after the start of an ordinary cycle, or 9 after reset release. The bench counts rising edges from each cycle start and compares `phase` with that count. It checks the state only on the edge where the count wraps, so a cycle that is one clock short or long shows up as a mismatch. Pause checks hold the pins for several edges and expect the frozen phase after each one.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_DMA   = 2'd2,
    ST_INTR  = 2'd3
  } mstate_t;

  // Code equals {clear_n, wait_n}
  typedef enum logic [1:0] {
    MD_LOAD  = 2'd0,
    MD_RESET = 2'd1,
    MD_PAUSE = 2'd2,
    MD_RUN   = 2'd3
  } mode_t;
endpackage

// File: rtl/seq_mode_decode.sv
module seq_mode_decode
  import seq_pkg::*;
(
  input  logic clear_n,
  input  logic wait_n,
  output logic hold_rst,
  output logic advance,
  output logic is_load
);
  mode_t mode;

  always_comb begin
    mode     = mode_t'({clear_n, wait_n});
    hold_rst = (mode == MD_RESET);
    advance  = (mode == MD_RUN) || (mode == MD_LOAD);
    is_load  = (mode == MD_LOAD);
  end
endmodule

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
  parameter int CYCLE_CLKS = 8,
  parameter int INIT_CLKS  = 9,
  parameter int TPA_AT     = 1,
  parameter int TPB_AT     = 6,
  parameter int PW         = $clog2(INIT_CLKS + 1)
) (
  input  logic          clk,
  input  logic          hold_rst,
  input  logic          advance,
  input  logic          in_init,
  output logic [PW-1:0] phase,
  output logic          cycle_end,
  output logic          tpa,
  output logic          tpb
);
  localparam logic [PW-1:0] LAST_RUN  = PW'(CYCLE_CLKS - 1);
  localparam logic [PW-1:0] LAST_INIT = PW'(INIT_CLKS - 1);

  logic [PW-1:0] last;

  always_comb begin
    last      = in_init ? LAST_INIT : LAST_RUN;
    cycle_end = advance && (phase == last);
    tpa       = !hold_rst && (phase == PW'(TPA_AT));
    tpb       = !hold_rst && (phase == PW'(TPB_AT));
  end

  always_ff @(negedge clk) begin
    if (hold_rst)       phase <= '0;
    else if (advance)   phase <= (phase == last) ? '0 : phase + 1'b1;
  end

  // R5: ordinary cycles never count past their last clock
  p_phase_range_r5: assert property (@(negedge clk) disable iff (hold_rst)
    !in_init |-> (phase < PW'(CYCLE_CLKS)));

  // R10: tpa lasts a single clock while timing runs
  p_tpa_single_r10: assert property (@(negedge clk) disable iff (hold_rst)
    (tpa && advance) |=> !tpa);

  // R9: pause freezes the count
  p_pause_hold_r9: assert property (@(negedge clk) disable iff (hold_rst)
    !advance |=> $stable(phase));

  // R2: reset returns the count to zero
  p_reset_phase_r2: assert property (@(negedge clk)
    hold_rst |=> (phase == '0));
endmodule

// File: rtl/seq_state_ctrl.sv
module seq_state_ctrl
  import seq_pkg::*;
(
  input  logic    clk,
  input  logic    hold_rst,
  input  logic    advance,
  input  logic    is_load,
  input  logic    cycle_end,
  input  logic    dma_in_req,
  input  logic    dma_out_req,
  input  logic    int_req,
  input  logic    int_en,
  input  logic    long_exec,
  output mstate_t cur,
  output logic    in_init
);
  logic    second;
  logic    nxt_second;
  mstate_t nxt;
  mstate_t svc;
  logic    dma_any;
  logic    irq_ok;

  always_comb begin
    dma_any = dma_in_req || dma_out_req;
    irq_ok  = int_req && int_en && !is_load;
    if (dma_any)      svc = ST_DMA;
    else if (irq_ok)  svc = ST_INTR;
    else if (is_load) svc = ST_EXEC;
    else              svc = ST_FETCH;

    nxt_second = 1'b0;
    nxt        = svc;
    if (in_init) begin
      nxt = dma_any ? ST_DMA : (is_load ? ST_EXEC : ST_FETCH);
    end else begin
      case (cur)
        ST_FETCH: nxt = ST_EXEC;
        ST_EXEC: begin
          if (!is_load && long_exec && !second) begin
            nxt        = ST_EXEC;
            nxt_second = 1'b1;
          end
        end
        default: nxt = svc;
      endcase
    end
  end

  always_ff @(negedge clk) begin
    if (hold_rst) begin
      cur     <= ST_EXEC;
      in_init <= 1'b1;
      second  <= 1'b0;
    end else if (cycle_end) begin
      cur     <= nxt;
      in_init <= 1'b0;
      second  <= nxt_second;
    end
  end

  // R2: reset parks the machine in execute with init pending
  p_reset_state_r2: assert property (@(negedge clk)
    hold_rst |=> (cur == ST_EXEC && in_init));

  // R3: the initialization cycle is spent in execute
  p_init_exec_r3: assert property (@(negedge clk) disable iff (hold_rst)
    in_init |-> (cur == ST_EXEC));

  // R4: no interrupt cycle right after initialization
  p_after_init_r4: assert property (@(negedge clk) disable iff (hold_rst)
    (in_init && cycle_end) |=> (cur != ST_INTR));

  // R9: pause holds the state code
  p_pause_state_r9: assert property (@(negedge clk) disable iff (hold_rst)
    !advance |=> $stable(cur));

  // R11: load mode never fetches
  p_load_no_fetch_r11: assert property (@(negedge clk) disable iff (hold_rst)
    (is_load && cycle_end) |=> (cur != ST_FETCH));

  // R6: fetch always leads into execute
  p_fetch_exec_r6: assert property (@(negedge clk) disable iff (hold_rst)
    (cur == ST_FETCH && cycle_end && !in_init) |=> (cur == ST_EXEC));
endmodule

// File: rtl/cycle_sequencer.sv
module cycle_sequencer
  import seq_pkg::*;
#(
  parameter int CYCLE_CLKS = 8,
  parameter int INIT_CLKS  = 9,
  parameter int TPA_AT     = 1,
  parameter int TPB_AT     = 6,
  localparam int PW        = $clog2(INIT_CLKS + 1)
) (
  input  logic          clk,
  input  logic          clear_n,
  input  logic          wait_n,
  input  logic          dma_in_req,
  input  logic          dma_out_req,
  input  logic          int_req,
  input  logic          int_en,
  input  logic          long_exec,
  output logic [1:0]    state,
  output logic [PW-1:0] phase,
  output logic          tpa,
  output logic          tpb,
  output logic          reg_clear,
  output logic          init_cycle,
  output logic          load_mode
);
  logic    hold_rst;
  logic    advance;
  logic    is_load;
  logic    cycle_end;
  logic    in_init;
  mstate_t cur;

  seq_mode_decode u_mode (
    .clear_n  (clear_n),
    .wait_n   (wait_n),
    .hold_rst (hold_rst),
    .advance  (advance),
    .is_load  (is_load)
  );

  seq_phase_timer #(
    .CYCLE_CLKS (CYCLE_CLKS),
    .INIT_CLKS  (INIT_CLKS),
    .TPA_AT     (TPA_AT),
    .TPB_AT     (TPB_AT),
    .PW         (PW)
  ) u_timer (
    .clk       (clk),
    .hold_rst  (hold_rst),
    .advance   (advance),
    .in_init   (in_init),
    .phase     (phase),
    .cycle_end (cycle_end),
    .tpa       (tpa),
    .tpb       (tpb)
  );

  seq_state_ctrl u_ctrl (
    .clk         (clk),
    .hold_rst    (hold_rst),
    .advance     (advance),
    .is_load     (is_load),
    .cycle_end   (cycle_end),
    .dma_in_req  (dma_in_req),
    .dma_out_req (dma_out_req),
    .int_req     (int_req),
    .int_en      (int_en),
    .long_exec   (long_exec),
    .cur         (cur),
    .in_init     (in_init)
  );

  assign state      = cur;
  assign reg_clear  = hold_rst;
  assign init_cycle = in_init;
  assign load_mode  = is_load;
endmodule

// File: tb/cycle_sequencer_test.sv
module cycle_sequencer_test;
  logic       clk = 1'b0;
  logic       clear_n = 1'b0, wait_n = 1'b1;
  logic       dma_in_req = 1'b0, dma_out_req = 1'b0;
  logic       int_req = 1'b0, int_en = 1'b0, long_exec = 1'b0;
  logic [1:0] state;
  logic [3:0] phase;
  logic       tpa, tpb, reg_clear, init_cycle, load_mode;
  int         n_tests = 0;
  int         n_fail  = 0;

  always #2 clk = ~clk;

  cycle_sequencer uut (
    .clk(clk), .clear_n(clear_n), .wait_n(wait_n),
    .dma_in_req(dma_in_req), .dma_out_req(dma_out_req),
    .int_req(int_req), .int_en(int_en), .long_exec(long_exec),
    .state(state), .phase(phase), .tpa(tpa), .tpb(tpb),
    .reg_clear(reg_clear), .init_cycle(init_cycle), .load_mode(load_mode)
  );

  // {dma_in, dma_out, irq, ie, long, cur[1:0], nxt[1:0]}
  localparam int NV = 15;
  localparam logic [8:0] VEC [NV] = '{
    9'b00000_00_01, 9'b00110_01_11, 9'b00000_11_00, 9'b00001_00_01,
    9'b00001_01_01, 9'b10001_01_10, 9'b10000_10_10, 9'b00110_10_11,
    9'b01000_11_10, 9'b00000_10_00, 9'b10000_00_01, 9'b00100_01_00,
    9'b00000_00_01, 9'b01110_01_10, 9'b00000_10_00
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_req(input logic [4:0] r);
    {dma_in_req, dma_out_req, int_req, int_en, long_exec} = r;
  endtask

  // run one 8-clock cycle from phase 0, checking phase and pulses
  task automatic run_cycle(input logic [1:0] cur, input logic [1:0] nxt, input string req);
    for (int k = 1; k <= 8; k++) begin
      tick();
      if (k < 8) begin
        chk(phase == 4'(k), "R5 phase", phase, k);
        chk(state == cur, "R5 state held", state, cur);
        chk(tpa == (k == 1), "R10 tpa", tpa, (k == 1));
        chk(tpb == (k == 6), "R10 tpb", tpb, (k == 6));
      end else begin
        chk(phase == 4'd0, "R5 wrap", phase, 0);
        chk(state == nxt, req, state, nxt);
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R2 / R1: reset held
    repeat (3) tick();
    chk(state == 2'b01, "R2 state", state, 1);
    chk(phase == 4'd0, "R2 phase", phase, 0);
    chk(!tpa && !tpb, "R2 pulses", {tpa, tpb}, 0);
    chk(reg_clear, "R1 reg_clear in reset", reg_clear, 1);
    chk(!load_mode, "R1 load_mode in reset", load_mode, 0);

    // R3: 9-clock init in run mode
    clear_n = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      tick();
      chk(phase == 4'(k), "R3 init phase", phase, k);
      chk(state == 2'b01 && init_cycle, "R3 init state", state, 1);
    end
    tick();
    chk(state == 2'b00, "R4 fetch after init", state, 0);
    chk(!init_cycle, "R3 init ends", init_cycle, 0);
    chk(!reg_clear, "R1 reg_clear in run", reg_clear, 0);

    // R6 R7 R8 R10: table walk
    for (int i = 0; i < NV; i++) begin
      chk(state == VEC[i][3:2], "R7 cycle start state", state, VEC[i][3:2]);
      set_req(VEC[i][8:4]);
      run_cycle(VEC[i][3:2], VEC[i][1:0], "R7 next state");
    end
    set_req(5'b0);

    // R9: pause mid-cycle
    repeat (3) tick();
    chk(phase == 4'd3, "R9 pre-pause phase", phase, 3);
    wait_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(phase == 4'd3, "R9 paused phase", phase, 3);
      chk(state == 2'b00, "R9 paused state", state, 0);
      chk(!load_mode && !reg_clear, "R1 pause flags", {load_mode, reg_clear}, 0);
    end
    wait_n = 1'b1;
    tick();
    chk(phase == 4'd4, "R9 resume phase", phase, 4);

    // R2 mid-cycle reset, then R3/R4 init with pending requests
    clear_n = 1'b0;
    tick();
    chk(state == 2'b01 && phase == 4'd0, "R2 mid-cycle reset", phase, 0);
    chk(!tpa && !tpb, "R2 pulses low", {tpa, tpb}, 0);
    set_req(5'b01110);
    clear_n = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      tick();
      chk(state == 2'b01, "R3 requests held off", state, 1);
    end
    tick();
    chk(state == 2'b10, "R4 DMA after init", state, 2);
    set_req(5'b00110);
    run_cycle(2'b10, 2'b11, "R7 interrupt after DMA");
    set_req(5'b0);

    // R11: load mode
    clear_n = 1'b0;
    repeat (2) tick();
    wait_n = 1'b0;
    tick();
    chk(load_mode, "R1 load_mode", load_mode, 1);
    for (int k = 2; k <= 9; k++) tick();
    chk(state == 2'b01 && phase == 4'd0, "R11 idle after init", state, 1);
    set_req(5'b00111);
    run_cycle(2'b01, 2'b01, "R11 irq and long ignored");
    set_req(5'b10000);
    run_cycle(2'b01, 2'b10, "R11 DMA-in in load");
    set_req(5'b0);
    run_cycle(2'b10, 2'b01, "R11 back to idle not fetch");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule